// File: doc/BRIEF.md
# SPI Bit-Rate and Select Timing Generator

This block produces the serial clock and the chip-select framing for one SPI master access. A programmable 8-bit rate value sets how many module clocks make up each half period of the serial clock. Three 3-bit delay fields, each with its own enable bit, control the access timing. One sets the time from select assertion to the first clock edge. One sets the time from the last clock edge to select release. The third sets the minimum idle gap before the next access may start. Clock polarity and phase are selectable. The block emits a one-cycle sample strobe and a one-cycle shift strobe, so that an external shifter can move data on the correct edges.

An access begins with a start pulse and carries a frame length and a last-frame flag. If a frame is not the last, the select line stays asserted after it and the block waits for the next start. That next frame begins shifting at once, with no lead delay. When no frame is being shifted, the serial data output can be held at a fixed programmed level. Otherwise it passes the shifter's bit through.

Top module: `spi_timing_gen`

## Requirements
- R1: One serial-clock half period lasts (rate_i + 1) module clocks. With rate_i = 0, SCK changes on every module clock. With rate_i = 255, a half period is 256 clocks.
- R2: The first SCK edge of an access comes exactly Dc serial-clock periods after select assertion, that is 2·Dc·(rate_i+1) module clocks. Dc = clk_dly_i + 1 when enabled.
- R3: Select is released exactly Dn periods after the last SCK edge of a last frame. Dn = neg_dly_i + 1 when enabled.
- R4: After select release, busy_o stays high for Dx further periods. Dx = nxt_dly_i + 1 when enabled. Then busy_o falls and a new start is accepted.
- R5: dly_en_i bit 2 enables the clock delay, bit 1 enables the negation delay and bit 0 enables the next-access delay. A delay whose bit is clear lasts one period, whatever its field holds.
- R6: SCK rests at cpol_i whenever no frame is being shifted, and it returns to that level at the last edge of each frame.
- R7: Edges are numbered from 1 within a frame. With cpha_i = 0, sample_o pulses for one clock on odd edges and shift_o on even edges. With cpha_i = 1 this is reversed. Each strobe is high in the same clock in which SCK changes.
- R8: While an access is active, ssl_o[sel_i] equals sel_pol_i[sel_i], where 1 means active-high. Every other line, and every line when no access is active, sits at the inverse of its polarity bit.
- R9: When mosi_fix_en_i is 1 and no frame is being shifted, mosi_o equals mosi_fix_val_i. Otherwise mosi_o follows mosi_data_i.
- R10: A frame has bits_i + 1 SCK periods (1 to 32), which gives 2·(bits_i+1) edges.
- R11: After a frame with last_i = 0, busy_o drops and select stays asserted. A start then begins shifting the next frame directly, and its first edge comes one half period after the cycle following the start.
- R12: A start pulse while busy_o is high is ignored.
- R13: Under reset, busy_o and both strobes are 0, SCK equals cpol_i and every select line is negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a frame |
| last_i | input | 1 | Frame is the last of the access |
| bits_i | input | 5 | Frame length minus one, in bits |
| sel_i | input | 1 | Index of the select line to drive |
| rate_i | input | 8 | Bit-rate divider value |
| clk_dly_i | input | 3 | Clock delay field (periods minus one) |
| neg_dly_i | input | 3 | Negation delay field (periods minus one) |
| nxt_dly_i | input | 3 | Next-access delay field (periods minus one) |
| dly_en_i | input | 3 | Delay enables: [2] clock, [1] negation, [0] next-access |
| cpol_i | input | 1 | Idle level of SCK |
| cpha_i | input | 1 | Sample on second edge when 1 |
| sel_pol_i | input | 2 | Per-line select polarity, 1 = active-high |
| mosi_fix_en_i | input | 1 | Hold MOSI at a fixed level when not shifting |
| mosi_fix_val_i | input | 1 | Fixed MOSI idle level |
| mosi_data_i | input | 1 | Data bit from the shifter |
| sck_o | output | 1 | Serial clock |
| ssl_o | output | 2 | Select lines |
| sample_o | output | 1 | One-cycle sample strobe |
| shift_o | output | 1 | One-cycle shift strobe |
| mosi_o | output | 1 | Serial data output |
| busy_o | output | 1 | Access in progress |

## Verification
The bench targets rate 0, where every module clock is an edge. A divider that is off by one there either stalls or produces half-length bits. It also covers the largest rate, where a too-narrow counter would wrap early. It mixes enabled and disabled delays, with disabled fields holding non-zero values, so that a design reading a field without checking its enable gives visibly longer select or idle windows. The bench fires a start in the middle of an access, which a design that does not ignore it would restart. It also runs a chained pair of frames, where a design that drops select between frames, or repeats the lead delay, fails the per-cycle comparison. Single-bit and 32-bit frames expose edge counters that are off by one at either end, and both phase settings expose swapped sample and shift strobes.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_XFER  = 3'd2,
    ST_TRAIL = 3'd3,
    ST_GAP   = 3'd4,
    ST_HOLD  = 3'd5
  } tg_state_e;

endpackage

// File: rtl/spi_tg_prescaler.sv
module spi_tg_prescaler #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              wrap;

  assign wrap = (cnt_q == rate_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + RATE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i && wrap;

  // R1: the divider never runs past the programmed rate
  assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    run_i |-> (cnt_q <= rate_i));

  // R1: with a non-zero rate, two ticks are never adjacent
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_o && rate_i != '0 && $stable(rate_i)) |=> !tick_o);

endmodule

// File: rtl/spi_tg_sequencer.sv
module spi_tg_sequencer
  import spi_tg_pkg::*;
#(
  parameter int BITS_W = 5,
  parameter int DLY_W  = 3,
  parameter int SEL_W  = 1,
  parameter int TCNT_W = 7
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [2:0]        dly_en_i,
  input  logic [DLY_W-1:0]  clk_dly_i,
  input  logic [DLY_W-1:0]  neg_dly_i,
  input  logic [DLY_W-1:0]  nxt_dly_i,
  output tg_state_e         state_o,
  output logic              run_o,
  output logic              edge_o,
  output logic              lead_edge_o,
  output logic [SEL_W-1:0]  sel_o
);

  tg_state_e         state_q, state_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [TCNT_W-1:0] goal;
  logic              hit;
  logic              load_all, load_frame;

  logic [BITS_W-1:0] bits_q;
  logic              last_q;
  logic [SEL_W-1:0]  sel_q;
  logic [DLY_W-1:0]  lead_q, neg_q, gap_q;

  // phase length in prescaler ticks
  always_comb begin
    unique case (state_q)
      ST_LEAD:  goal = (TCNT_W'(lead_q) << 1) + TCNT_W'(1);
      ST_XFER:  goal = (TCNT_W'(bits_q) + TCNT_W'(1)) << 1;
      ST_TRAIL: goal = (TCNT_W'(neg_q) + TCNT_W'(1)) << 1;
      ST_GAP:   goal = (TCNT_W'(gap_q) + TCNT_W'(1)) << 1;
      default:  goal = TCNT_W'(1);
    endcase
  end

  assign run_o = (state_q == ST_LEAD) || (state_q == ST_XFER) ||
                 (state_q == ST_TRAIL) || (state_q == ST_GAP);
  assign hit   = tick_i && ((tcnt_q + TCNT_W'(1)) == goal);

  always_comb begin
    state_d    = state_q;
    tcnt_d     = tcnt_q;
    load_all   = 1'b0;
    load_frame = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_LEAD;
          tcnt_d   = '0;
          load_all = 1'b1;
        end
      end
      ST_HOLD: begin
        if (start_i) begin
          state_d    = ST_XFER;
          tcnt_d     = '0;
          load_frame = 1'b1;
        end
      end
      default: begin
        if (tick_i) begin
          if (hit) begin
            tcnt_d = '0;
            unique case (state_q)
              ST_LEAD:  state_d = ST_XFER;
              ST_XFER:  state_d = last_q ? ST_TRAIL : ST_HOLD;
              ST_TRAIL: state_d = ST_GAP;
              default:  state_d = ST_IDLE;
            endcase
          end else begin
            tcnt_d = tcnt_q + TCNT_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
    end
  end

  // per-frame settings
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      last_q <= 1'b1;
    end else if (load_all || load_frame) begin
      bits_q <= bits_i;
      last_q <= last_i;
    end
  end

  // per-access settings
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      lead_q <= '0;
      neg_q  <= '0;
      gap_q  <= '0;
    end else if (load_all) begin
      sel_q  <= sel_i;
      lead_q <= dly_en_i[2] ? clk_dly_i : '0;
      neg_q  <= dly_en_i[1] ? neg_dly_i : '0;
      gap_q  <= dly_en_i[0] ? nxt_dly_i : '0;
    end
  end

  assign state_o     = state_q;
  assign edge_o      = tick_i && (state_q == ST_XFER);
  assign lead_edge_o = ~tcnt_q[0];
  assign sel_o       = sel_q;

  // R10: the tick count never reaches the phase length
  assert_tcnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    run_o |-> (tcnt_q < goal));

  // R12: a start without a tick leaves a running phase unchanged
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_o && start_i && !tick_i) |=> (state_q == $past(state_q)));

  // R4: the idle gap only ends into the idle state
  assert_gap_exit_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> (state_q == ST_GAP || state_q == ST_IDLE));

  // R11: a start while holding select goes straight to shifting
  assert_hold_to_xfer_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_HOLD && start_i) |=> (state_q == ST_XFER));

endmodule

// File: rtl/spi_tg_outputs.sv
module spi_tg_outputs
  import spi_tg_pkg::*;
#(
  parameter int NUM_SEL = 2,
  parameter int SEL_W   = 1
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  tg_state_e          state_i,
  input  logic               edge_i,
  input  logic               lead_edge_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [NUM_SEL-1:0] sel_pol_i,
  input  logic               mosi_fix_en_i,
  input  logic               mosi_fix_val_i,
  input  logic               mosi_data_i,
  output logic               sck_o,
  output logic               sample_o,
  output logic               shift_o,
  output logic [NUM_SEL-1:0] ssl_o,
  output logic               busy_o,
  output logic               mosi_o
);

  logic ph_q, ph_d;
  logic samp_q, samp_d;
  logic shft_q, shft_d;
  logic sel_act;
  logic is_sample;

  assign is_sample = lead_edge_i ^ cpha_i;

  always_comb begin
    ph_d   = ph_q;
    samp_d = 1'b0;
    shft_d = 1'b0;
    if (edge_i) begin
      ph_d   = ~ph_q;
      samp_d = is_sample;
      shft_d = ~is_sample;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      samp_q <= 1'b0;
      shft_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      samp_q <= samp_d;
      shft_q <= shft_d;
    end
  end

  assign sck_o    = cpol_i ^ ph_q;
  assign sample_o = samp_q;
  assign shift_o  = shft_q;

  assign sel_act = (state_i == ST_LEAD) || (state_i == ST_XFER) ||
                   (state_i == ST_TRAIL) || (state_i == ST_HOLD);
  assign busy_o  = (state_i == ST_LEAD) || (state_i == ST_XFER) ||
                   (state_i == ST_TRAIL) || (state_i == ST_GAP);

  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_ssl
    assign ssl_o[gi] = (sel_act && (sel_i == SEL_W'(gi))) ? sel_pol_i[gi] : ~sel_pol_i[gi];
  end

  assign mosi_o = (mosi_fix_en_i && (state_i != ST_XFER)) ? mosi_fix_val_i : mosi_data_i;

  // R7: never both strobes at once
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(sample_o && shift_o));

  // R7: every SCK change carries exactly one strobe
  assert_edge_strobe_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(ph_q) |-> (samp_q || shft_q));

  // R6: SCK rests at its idle level outside shifting
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_i != ST_XFER) |-> !ph_q);

  // R8: at most one select line active
  assert_ssl_onehot_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(ssl_o ^ ~sel_pol_i));

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
  import spi_tg_pkg::*;
#(
  parameter int RATE_W  = 8,
  parameter int DLY_W   = 3,
  parameter int BITS_W  = 5,
  parameter int NUM_SEL = 2,
  localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
  localparam int TCNT_W = ((BITS_W > DLY_W) ? BITS_W : DLY_W) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               last_i,
  input  logic [BITS_W-1:0]  bits_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [DLY_W-1:0]   clk_dly_i,
  input  logic [DLY_W-1:0]   neg_dly_i,
  input  logic [DLY_W-1:0]   nxt_dly_i,
  input  logic [2:0]         dly_en_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic [NUM_SEL-1:0] sel_pol_i,
  input  logic               mosi_fix_en_i,
  input  logic               mosi_fix_val_i,
  input  logic               mosi_data_i,
  output logic               sck_o,
  output logic [NUM_SEL-1:0] ssl_o,
  output logic               sample_o,
  output logic               shift_o,
  output logic               mosi_o,
  output logic               busy_o
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync_q[1];

  tg_state_e        state;
  logic             run, tick, edge_ev, lead_edge;
  logic [SEL_W-1:0] sel_act;

  spi_tg_prescaler #(
    .RATE_W (RATE_W)
  ) u_presc (
    .clk    (clk),
    .rst_ni (rst_ni),
    .run_i  (run),
    .rate_i (rate_i),
    .tick_o (tick)
  );

  spi_tg_sequencer #(
    .BITS_W (BITS_W),
    .DLY_W  (DLY_W),
    .SEL_W  (SEL_W),
    .TCNT_W (TCNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .start_i     (start_i),
    .last_i      (last_i),
    .bits_i      (bits_i),
    .sel_i       (sel_i),
    .dly_en_i    (dly_en_i),
    .clk_dly_i   (clk_dly_i),
    .neg_dly_i   (neg_dly_i),
    .nxt_dly_i   (nxt_dly_i),
    .state_o     (state),
    .run_o       (run),
    .edge_o      (edge_ev),
    .lead_edge_o (lead_edge),
    .sel_o       (sel_act)
  );

  spi_tg_outputs #(
    .NUM_SEL (NUM_SEL),
    .SEL_W   (SEL_W)
  ) u_out (
    .clk            (clk),
    .rst_ni         (rst_ni),
    .state_i        (state),
    .edge_i         (edge_ev),
    .lead_edge_i    (lead_edge),
    .sel_i          (sel_act),
    .cpol_i         (cpol_i),
    .cpha_i         (cpha_i),
    .sel_pol_i      (sel_pol_i),
    .mosi_fix_en_i  (mosi_fix_en_i),
    .mosi_fix_val_i (mosi_fix_val_i),
    .mosi_data_i    (mosi_data_i),
    .sck_o          (sck_o),
    .sample_o       (sample_o),
    .shift_o        (shift_o),
    .ssl_o          (ssl_o),
    .busy_o         (busy_o),
    .mosi_o         (mosi_o)
  );

endmodule

// File: tb/spi_timing_gen_tb_top.sv
`timescale 1ns/1ps
module spi_timing_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, last_i;
  logic [4:0] bits_i;
  logic       sel_i;
  logic [7:0] rate_i;
  logic [2:0] clk_dly_i, neg_dly_i, nxt_dly_i, dly_en_i;
  logic       cpol_i, cpha_i;
  logic [1:0] sel_pol_i;
  logic       mosi_fix_en_i, mosi_fix_val_i, mosi_data_i;
  logic       sck_o, sample_o, shift_o, mosi_o, busy_o;
  logic [1:0] ssl_o;

  always #2.5 clk = ~clk;

  spi_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last_i), .bits_i(bits_i),
    .sel_i(sel_i), .rate_i(rate_i), .clk_dly_i(clk_dly_i), .neg_dly_i(neg_dly_i),
    .nxt_dly_i(nxt_dly_i), .dly_en_i(dly_en_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .sel_pol_i(sel_pol_i), .mosi_fix_en_i(mosi_fix_en_i), .mosi_fix_val_i(mosi_fix_val_i),
    .mosi_data_i(mosi_data_i), .sck_o(sck_o), .ssl_o(ssl_o), .sample_o(sample_o),
    .shift_o(shift_o), .mosi_o(mosi_o), .busy_o(busy_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_en = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // m_st: 0 idle, 1 lead, 2 shifting, 3 trailing, 4 gap, 5 holding select
  int m_st, m_el, m_len, m_h, m_bits, m_sel, m_dc, m_dn, m_dx;
  bit m_last, m_pend;

  function automatic int per(input bit en, input logic [2:0] f);
    return en ? int'(f) + 1 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_el = 0; m_len = 0; m_pend = 1'b0;
    end else begin
      m_pend = 1'b0;
      if (m_st == 0) begin
        if (start_i) begin
          m_h = int'(rate_i) + 1; m_bits = int'(bits_i) + 1; m_last = last_i;
          m_sel = int'(sel_i);
          m_dc = per(dly_en_i[2], clk_dly_i);
          m_dn = per(dly_en_i[1], neg_dly_i);
          m_dx = per(dly_en_i[0], nxt_dly_i);
          m_st = 1; m_el = 0; m_len = (2 * m_dc - 1) * m_h;
        end
      end else if (m_st == 5) begin
        if (start_i) begin
          m_bits = int'(bits_i) + 1; m_last = last_i;
          m_st = 2; m_el = 0; m_len = 2 * m_bits * m_h;
        end
      end else begin
        m_el++;
        if (m_el == m_len) begin
          m_el = 0;
          case (m_st)
            1: begin m_st = 2; m_len = 2 * m_bits * m_h; end
            2: begin
              m_pend = 1'b1;
              if (m_last) begin m_st = 3; m_len = 2 * m_dn * m_h; end
              else m_st = 5;
            end
            3: begin m_st = 4; m_len = 2 * m_dx * m_h; end
            default: m_st = 0;
          endcase
        end
      end
    end
  end

  // ---------------- per-access measurement counters ----------------
  int  c_ssl, c_busy, c_edges, c_samp, c_shift, c_first, c_second;
  bit  prev_sck;

  task automatic clear_meas();
    c_ssl = 0; c_busy = 0; c_edges = 0; c_samp = 0; c_shift = 0;
    c_first = -1; c_second = -1; prev_sck = sck_o;
  endtask

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cyc++;
    mosi_data_i <= cyc[0] ^ cyc[2];
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (cmp_en) begin
      automatic bit e_act  = (m_st == 1 || m_st == 2 || m_st == 3 || m_st == 5);
      automatic bit e_busy = (m_st >= 1 && m_st <= 4);
      automatic int k      = 0;
      automatic bit e_sck  = cpol_i;
      automatic bit e_samp = 1'b0, e_shift = 1'b0;
      automatic bit e_mosi;
      automatic logic [1:0] e_ssl;
      if (m_st == 2) begin
        e_sck = cpol_i ^ ((m_el / m_h) % 2 == 1);
        if (m_el > 0 && (m_el % m_h) == 0) k = m_el / m_h;
      end
      if (m_pend) k = 2 * m_bits;
      if (k > 0) begin
        if ((k % 2 == 1) ^ cpha_i) e_samp = 1'b1; else e_shift = 1'b1;
      end
      for (int i = 0; i < 2; i++)
        e_ssl[i] = (e_act && m_sel == i) ? sel_pol_i[i] : ~sel_pol_i[i];
      e_mosi = (mosi_fix_en_i && m_st != 2) ? mosi_fix_val_i : mosi_data_i;
      chk(sck_o == e_sck, "R1 R6 sck", sck_o, e_sck);
      chk(sample_o == e_samp, "R7 sample", sample_o, e_samp);
      chk(shift_o == e_shift, "R7 shift", shift_o, e_shift);
      chk(ssl_o == e_ssl, "R8 ssl", ssl_o, e_ssl);
      chk(busy_o == e_busy, "R12 busy", busy_o, e_busy);
      chk(mosi_o == e_mosi, "R9 mosi", mosi_o, e_mosi);
      // measurements from the outputs themselves
      if (ssl_o[sel_i] == sel_pol_i[sel_i]) c_ssl++;
      if (busy_o) c_busy++;
      if (sample_o) c_samp++;
      if (shift_o) c_shift++;
      if (sck_o != prev_sck) begin
        c_edges++;
        if (c_edges == 1) c_first = c_ssl - 1;
        if (c_edges == 2) c_second = c_ssl - 1;
      end
      prev_sck = sck_o;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_st != 0);
  endtask

  task automatic access(input int rate, input logic [2:0] en, input logic [2:0] dc,
                        input logic [2:0] dn, input logic [2:0] dx, input int bits,
                        input bit pol, input bit pha, input bit sel, input logic [1:0] sp,
                        input bit poke);
    automatic int h, b, pc, pn, px;
    @(negedge clk);
    rate_i = 8'(rate); dly_en_i = en; clk_dly_i = dc; neg_dly_i = dn; nxt_dly_i = dx;
    bits_i = 5'(bits); cpol_i = pol; cpha_i = pha; sel_i = sel; sel_pol_i = sp; last_i = 1'b1;
    @(negedge clk); @(negedge clk);
    clear_meas();
    pulse_start();
    if (poke) begin
      @(negedge clk); @(negedge clk);
      pulse_start();  // R12: must be ignored
    end
    wait_idle();
    h = rate + 1; b = bits + 1;
    pc = per(en[2], dc); pn = per(en[1], dn); px = per(en[0], dx);
    chk(c_first == 2 * pc * h, "R2 R5 lead", c_first, 2 * pc * h);
    chk(c_second - c_first == h, "R1 half period", c_second - c_first, h);
    chk(c_ssl == (2 * pc - 1 + 2 * b + 2 * pn) * h, "R3 R5 select window", c_ssl,
        (2 * pc - 1 + 2 * b + 2 * pn) * h);
    chk(c_busy - c_ssl == 2 * px * h, "R4 R5 gap", c_busy - c_ssl, 2 * px * h);
    chk(c_edges == 2 * b, "R10 edges", c_edges, 2 * b);
    chk(c_samp == b && c_shift == b, "R7 strobe count", c_samp * 100 + c_shift, b * 100 + b);
    if (poke) chk(c_busy == (2 * pc - 1 + 2 * b + 2 * pn + 2 * px) * h, "R12 ignored start",
                  c_busy, (2 * pc - 1 + 2 * b + 2 * pn + 2 * px) * h);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; last_i = 1'b1; bits_i = '0; sel_i = 1'b0;
    rate_i = '0; clk_dly_i = '0; neg_dly_i = '0; nxt_dly_i = '0; dly_en_i = '0;
    cpol_i = 1'b1; cpha_i = 1'b0; sel_pol_i = 2'b01; mosi_fix_en_i = 1'b1;
    mosi_fix_val_i = 1'b1; mosi_data_i = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(busy_o == 1'b0, "R13 busy", busy_o, 0);
    chk(sck_o == 1'b1, "R13 sck", sck_o, 1);
    chk(ssl_o == 2'b10, "R13 ssl", ssl_o, 2);
    chk(sample_o == 1'b0 && shift_o == 1'b0, "R13 strobes", sample_o + shift_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_en = 1'b1;

    // fastest rate, all delays disabled with non-zero fields, fixed MOSI idle
    access(0, 3'b000, 3'd5, 3'd6, 3'd7, 7, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    // all delays enabled, opposite phase and polarity, second select line active-high
    mosi_fix_val_i = 1'b0;
    access(2, 3'b111, 3'd2, 3'd7, 3'd0, 3, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0);
    // mixed enables, single-bit frame, start poked mid-access
    mosi_fix_en_i = 1'b0;
    access(1, 3'b101, 3'd5, 3'd7, 3'd3, 0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1);
    // slowest rate
    access(255, 3'b000, 3'd0, 3'd0, 3'd0, 0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0);
    // longest frame with maximum lead
    mosi_fix_en_i = 1'b1; mosi_fix_val_i = 1'b1;
    access(3, 3'b100, 3'd7, 3'd0, 3'd0, 31, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1);

    // R11: chained frames with select held between them
    @(negedge clk);
    rate_i = 8'd1; dly_en_i = 3'b000; bits_i = 5'd3; last_i = 1'b0;
    cpol_i = 1'b0; cpha_i = 1'b0; sel_i = 1'b0; sel_pol_i = 2'b00;
    @(negedge clk);
    clear_meas();
    pulse_start();
    do @(negedge clk); while (m_st != 5);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R11 busy low while holding", busy_o, 0);
    chk(ssl_o == 2'b10, "R11 select held", ssl_o, 2);
    bits_i = 5'd1; last_i = 1'b1;
    pulse_start();
    wait_idle();
    chk(c_edges == 12, "R10 R11 chained edges", c_edges, 12);
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule